// File: doc/BRIEF.md
# I2C Master Bus-Recovery Clock Pulser

This block gives an I2C master a way to free a bus on which a slave, having lost bit alignment, keeps SDA pulled low. Stuck in that state, the master cannot form a STOP condition. Software writes 1 to a request bit. If the block is eligible, it then emits exactly one SCL clock cycle with no data framing. The cycle is an open-drain low phase followed by a released high phase, and both phases are timed by the same prescale select and low/high period counts that normal transfers use. When the cycle completes, the request bit drops back to 0 by itself. Software therefore issues further pulses one at a time, and it watches a synchronized SDA status bit to see when the slave lets go before it reissues STOP.

A request is taken only when the bus is idle, or when this device is the master of a busy bus, and only when the normal master engine is not itself pulling SCL low. While no pulse is running, the drive requests of the master engine pass straight to the pins. During a pulse, SCL is owned by the pulser and SDA is released. Master arbitration-loss detection elsewhere in the controller should be disabled while these pulses are used.

Top module: `i2c_bus_recovery_pulser`

## Requirements
- R1: A cycle with `req_wr_i`=1 and `req_wdata_i`=1 while eligible and idle is accepted. From the next clock edge, `scl_oe_o`=1 (SCL pulled low), `busy_o`=1 and `req_o`=1.
- R2: The low phase holds `scl_oe_o`=1 for exactly (`brl_i`+1)·2^`cks_i` clock cycles. Each prescaled tick is 2^`cks_i` cycles.
- R3: After the low phase SCL is released. The sensed SCL passes a two-flop synchronizer and must read high in both stages. The high count then runs for (`brh_i`+1)·2^`cks_i` cycles. `busy_o` stays 1 for 3 + S + (`brh_i`+1)·2^`cks_i` cycles after release, where S is the number of extra cycles a slave holds SCL low.
- R4: Once the high phase ends, `req_o` and `busy_o` return to 0 by themselves. Only one SCL cycle is produced per accepted write.
- R5: A request is ignored when `bus_busy_i`=1 and `master_i`=0. It is accepted when `bus_busy_i`=0, or when both are 1.
- R6: A request is ignored while `scl_drv_low_i`=1.
- R7: A request written while a pulse is in progress is ignored. The pulse length is unchanged and no second cycle follows.
- R8: While `busy_o`=1, `sda_oe_o`=0 even if `sda_drv_low_i`=1. While idle, `scl_oe_o` follows `scl_drv_low_i` and `sda_oe_o` follows `sda_drv_low_i`.
- R9: `sda_level_o` equals `sda_i` as sampled two clock edges earlier.
- R10: After reset, `scl_oe_o`=0, `sda_oe_o` follows its idle input, `busy_o`=0, `req_o`=0 and `sda_level_o`=1.
- R11: A write with `req_wdata_i`=0 has no effect. No pulse starts and `req_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_wr_i | input | 1 | Write strobe for the request bit |
| req_wdata_i | input | 1 | Value written to the request bit |
| req_o | output | 1 | Request bit readback, cleared by hardware |
| busy_o | output | 1 | Pulse in progress |
| sda_level_o | output | 1 | Synchronized SDA line level |
| cks_i | input | CKS_W | Prescale select, tick = 2^cks_i cycles |
| brh_i | input | CNT_W | High-phase count, length brh_i+1 ticks |
| brl_i | input | CNT_W | Low-phase count, length brl_i+1 ticks |
| bus_busy_i | input | 1 | Bus busy flag |
| master_i | input | 1 | Device is master |
| scl_drv_low_i | input | 1 | Master engine pulls SCL low |
| sda_drv_low_i | input | 1 | Master engine pulls SDA low |
| scl_i | input | 1 | Sensed SCL line |
| sda_i | input | 1 | Sensed SDA line |
| scl_oe_o | output | 1 | SCL open-drain pull-low enable |
| sda_oe_o | output | 1 | SDA open-drain pull-low enable |

## Verification
If the phase counter or the prescaler is off by one, the length of `scl_oe_o` or of `busy_o` changes by a whole tick. That error is visible at the end of the very first pulse of a configuration, so the bench sweeps every low, high and prescale combination in a small range. A wrong phase state, or a wrong synchronizer depth, shifts the release-to-idle length by whole cycles. A stretched SCL line would show this as well. A broken eligibility or ownership path shows up at once as an unexpected pulse, or as SDA being pulled during a pulse.

// File: rtl/i2c_rcv_pkg.sv
package i2c_rcv_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;
endpackage

// File: rtl/i2c_rcv_sync.sv
module i2c_rcv_sync #(
  parameter int  STAGES  = 2,
  parameter bit  RST_VAL = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              d_i,
  output logic [STAGES-1:0] pipe_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign pipe_o = pipe_q;

  logic warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) warm_q <= 1'b0;
    else         warm_q <= 1'b1;
  end

  // R9
  sync_lag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_q |-> (pipe_q[0] == $past(d_i)));
endmodule

// File: rtl/i2c_rcv_prescale.sv
module i2c_rcv_prescale #(
  parameter int CKS_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CKS_W-1:0] cks_i,
  output logic             tick_o
);
  localparam int DIV_W = (1 << CKS_W) - 1;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  assign lim    = DIV_W'((64'd1 << cks_i) - 64'd1);
  assign tick_o = en_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end

  // R2
  div_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q <= lim));
endmodule

// File: rtl/i2c_rcv_phase_fsm.sv
module i2c_rcv_phase_fsm
  import i2c_rcv_pkg::*;
#(
  parameter int CKS_W = 3,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CKS_W-1:0] cks_i,
  input  logic [CNT_W-1:0] brl_i,
  input  logic [CNT_W-1:0] brh_i,
  input  logic             scl_hi_i,
  input  logic             tick_i,
  output logic [CKS_W-1:0] cks_o,
  output logic             pre_clr_o,
  output logic             pre_en_o,
  output logic             active_o,
  output logic             drive_low_o,
  output logic             done_o
);
  phase_e           st_q;
  logic [CNT_W-1:0] tc_q;
  logic [CNT_W-1:0] brl_q, brh_q;
  logic [CKS_W-1:0] cks_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= PH_IDLE;
      tc_q  <= '0;
      brl_q <= '0;
      brh_q <= '0;
      cks_q <= '0;
    end else begin
      unique case (st_q)
        PH_IDLE: if (start_i) begin
          st_q  <= PH_LOW;
          tc_q  <= '0;
          brl_q <= brl_i;
          brh_q <= brh_i;
          cks_q <= cks_i;
        end
        PH_LOW: if (tick_i) begin
          if (tc_q == brl_q) begin
            st_q <= PH_WAIT;
            tc_q <= '0;
          end else tc_q <= tc_q + 1'b1;
        end
        // high count starts only once SCL is seen released
        PH_WAIT: if (scl_hi_i) st_q <= PH_HIGH;
        PH_HIGH: if (tick_i) begin
          if (tc_q == brh_q) begin
            st_q <= PH_IDLE;
            tc_q <= '0;
          end else tc_q <= tc_q + 1'b1;
        end
        default: st_q <= PH_IDLE;
      endcase
    end
  end

  assign cks_o       = cks_q;
  assign pre_en_o    = (st_q == PH_LOW) || (st_q == PH_HIGH);
  assign pre_clr_o   = !pre_en_o;
  assign active_o    = (st_q != PH_IDLE);
  assign drive_low_o = (st_q == PH_LOW);
  assign done_o      = (st_q == PH_HIGH) && tick_i && (tc_q == brh_q);

  // R2
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == PH_LOW) |-> (tc_q <= brl_q)) and ((st_q == PH_HIGH) |-> (tc_q <= brh_q)));

  // R3
  hold_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == PH_WAIT) && !scl_hi_i) |=> (st_q == PH_WAIT));
endmodule

// File: rtl/i2c_bus_recovery_pulser.sv
module i2c_bus_recovery_pulser #(
  parameter int CKS_W = 3,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_wr_i,
  input  logic             req_wdata_i,
  output logic             req_o,
  output logic             busy_o,
  output logic             sda_level_o,
  input  logic [CKS_W-1:0] cks_i,
  input  logic [CNT_W-1:0] brh_i,
  input  logic [CNT_W-1:0] brl_i,
  input  logic             bus_busy_i,
  input  logic             master_i,
  input  logic             scl_drv_low_i,
  input  logic             sda_drv_low_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] scl_pipe, sda_pipe;
  logic              active, drive_low, done, tick, pre_clr, pre_en;
  logic              eligible, start, req_q;
  logic [CKS_W-1:0]  cks_run;

  i2c_rcv_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_scl_sync (
    .clk_i, .rst_ni, .d_i(scl_i), .pipe_o(scl_pipe)
  );

  i2c_rcv_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_sda_sync (
    .clk_i, .rst_ni, .d_i(sda_i), .pipe_o(sda_pipe)
  );

  i2c_rcv_prescale #(.CKS_W(CKS_W)) u_pre (
    .clk_i, .rst_ni, .clr_i(pre_clr), .en_i(pre_en), .cks_i(cks_run), .tick_o(tick)
  );

  i2c_rcv_phase_fsm #(.CKS_W(CKS_W), .CNT_W(CNT_W)) u_fsm (
    .clk_i, .rst_ni,
    .start_i(start), .cks_i, .brl_i, .brh_i,
    .scl_hi_i(&scl_pipe), .tick_i(tick),
    .cks_o(cks_run), .pre_clr_o(pre_clr), .pre_en_o(pre_en),
    .active_o(active), .drive_low_o(drive_low), .done_o(done)
  );

  assign eligible = (!bus_busy_i || master_i) && !scl_drv_low_i && !active;
  assign start    = req_wr_i && req_wdata_i && eligible;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    req_q <= 1'b0;
    else if (start) req_q <= 1'b1;
    else if (done)  req_q <= 1'b0;
  end

  assign req_o       = req_q;
  assign busy_o      = active;
  assign sda_level_o = sda_pipe[SYNC_N-1];
  assign scl_oe_o    = active ? drive_low : scl_drv_low_i;
  assign sda_oe_o    = active ? 1'b0 : sda_drv_low_i;

  // R1
  req_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_wr_i && req_wdata_i && !busy_o && !scl_drv_low_i && (!bus_busy_i || master_i))
    |=> (busy_o && req_o && scl_oe_o));

  // R5 R6
  req_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && (scl_drv_low_i || (bus_busy_i && !master_i))) |=> !busy_o);

  // R4
  self_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !req_o);

  // R7
  single_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !scl_oe_o) |=> (!busy_o || !scl_oe_o));
endmodule

// File: tb/i2c_bus_recovery_pulser_tb_top.sv
module i2c_bus_recovery_pulser_tb_top;
  localparam int CKS_W = 3;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_wr = 1'b0, req_wdata = 1'b0;
  logic req_o, busy_o, sda_level_o, scl_oe_o, sda_oe_o;
  logic [CKS_W-1:0] cks = '0;
  logic [CNT_W-1:0] brh = '0, brl = '0;
  logic bus_busy = 1'b0, master = 1'b0, scl_drv_low = 1'b0, sda_drv_low = 1'b0;
  logic hold = 1'b0, sda_line = 1'b1;
  logic scl_line;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit  done_flag = 1'b0;

  always #2 clk = ~clk;

  assign scl_line = !(scl_oe_o || hold);

  i2c_bus_recovery_pulser #(.CKS_W(CKS_W), .CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_wr_i(req_wr), .req_wdata_i(req_wdata),
    .req_o(req_o), .busy_o(busy_o), .sda_level_o(sda_level_o),
    .cks_i(cks), .brh_i(brh), .brl_i(brl),
    .bus_busy_i(bus_busy), .master_i(master),
    .scl_drv_low_i(scl_drv_low), .sda_drv_low_i(sda_drv_low),
    .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      finish_run();
    end
  end

  task automatic write_req(input bit val);
    req_wr = 1'b1; req_wdata = val;
    @(negedge clk);
    req_wr = 1'b0; req_wdata = 1'b0;
  endtask

  // issue a pulse and measure low and busy-after-release lengths
  task automatic run_pulse(input int stretch, input bit rewrite,
                           output int lc, output int hc, output int sda_bad);
    lc = 0; hc = 0; sda_bad = 0;
    write_req(1'b1);
    while (scl_oe_o && lc < 5000) begin
      if (sda_oe_o) sda_bad++;
      if (rewrite && lc == 0) begin req_wr = 1'b1; req_wdata = 1'b1; end
      else begin req_wr = 1'b0; req_wdata = 1'b0; end
      lc++;
      @(negedge clk);
    end
    req_wr = 1'b0; req_wdata = 1'b0;
    hold = (stretch > 0);
    while (busy_o && hc < 5000) begin
      if (sda_oe_o) sda_bad++;
      if (hc == stretch) hold = 1'b0;
      hc++;
      @(negedge clk);
    end
    hold = 1'b0;
  endtask

  task automatic idle_quiet(input int n, input string tag);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      if (scl_oe_o || busy_o || req_o) bad++;
      @(negedge clk);
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  initial begin
    int lc, hc, sb, d, exp_h;
    repeat (3) @(negedge clk);
    // R10
    chk(scl_oe_o == 1'b0 && busy_o == 1'b0 && req_o == 1'b0, "R10 reset outputs",
        {scl_oe_o, busy_o, req_o}, 0);
    chk(sda_level_o == 1'b1, "R10 sda level reset", sda_level_o, 1);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R2 R3 R4 sweep
    for (int c = 0; c < 3; c++) begin
      for (int l = 0; l < 4; l++) begin
        for (int h = 0; h < 4; h++) begin
          cks = CKS_W'(c); brl = CNT_W'(l); brh = CNT_W'(h);
          d = 1 << c;
          req_wr = 1'b1; req_wdata = 1'b1;
          @(negedge clk);
          req_wr = 1'b0; req_wdata = 1'b0;
          chk(scl_oe_o && busy_o && req_o, "R1 accept", {scl_oe_o, busy_o, req_o}, 7);
          lc = 0;
          while (scl_oe_o && lc < 5000) begin lc++; @(negedge clk); end
          chk(lc == (l + 1) * d, "R2 low length", lc, (l + 1) * d);
          hc = 0;
          while (busy_o && hc < 5000) begin hc++; @(negedge clk); end
          exp_h = 3 + (h + 1) * d;
          chk(hc == exp_h, "R3 high length", hc, exp_h);
          chk(!req_o, "R4 self clear", req_o, 0);
          repeat (2) @(negedge clk);
        end
      end
    end

    // R4 one cycle only
    cks = 3'd1; brl = 8'd1; brh = 8'd1;
    run_pulse(0, 1'b0, lc, hc, sb);
    idle_quiet(20, "R4 no further cycle");

    // R3 clock stretch
    for (int s = 1; s < 6; s += 2) begin
      run_pulse(s, 1'b0, lc, hc, sb);
      chk(hc == 3 + s + 4, "R3 stretch", hc, 3 + s + 4);
    end

    // R7 rewrite during pulse
    run_pulse(0, 1'b1, lc, hc, sb);
    chk(lc == 4, "R7 low unchanged", lc, 4);
    chk(hc == 7, "R7 high unchanged", hc, 7);
    idle_quiet(15, "R7 no second cycle");

    // R8 sda released during pulse, pass-through when idle
    sda_drv_low = 1'b1;
    @(negedge clk);
    chk(sda_oe_o == 1'b1, "R8 sda idle pass", sda_oe_o, 1);
    run_pulse(0, 1'b0, lc, hc, sb);
    chk(sb == 0, "R8 sda released", sb, 0);
    sda_drv_low = 1'b0;
    @(negedge clk);
    chk(sda_oe_o == 1'b0, "R8 sda idle follow", sda_oe_o, 0);

    // R5 bus busy, not master
    bus_busy = 1'b1; master = 1'b0;
    write_req(1'b1);
    idle_quiet(10, "R5 ignored busy not master");
    master = 1'b1;
    run_pulse(0, 1'b0, lc, hc, sb);
    chk(lc == 4, "R5 accepted busy master", lc, 4);
    bus_busy = 1'b0; master = 1'b0;
    run_pulse(0, 1'b0, lc, hc, sb);
    chk(lc == 4, "R5 accepted bus free", lc, 4);

    // R6 scl held by own engine
    scl_drv_low = 1'b1;
    write_req(1'b1);
    begin
      int bad = 0;
      for (int i = 0; i < 10; i++) begin
        if (busy_o || req_o || !scl_oe_o) bad++;
        @(negedge clk);
      end
      chk(bad == 0, "R6 ignored and R8 scl pass", bad, 0);
    end
    scl_drv_low = 1'b0;
    @(negedge clk);

    // R11 write of zero
    write_req(1'b0);
    idle_quiet(10, "R11 zero write");

    // R9 sda synchronizer latency
    for (int v = 0; v < 4; v++) begin
      sda_line = v[0];
      @(negedge clk);
      chk(sda_level_o == !v[0], "R9 one edge", sda_level_o, !v[0]);
      @(negedge clk);
      chk(sda_level_o == v[0], "R9 two edges", sda_level_o, v[0]);
    end

    finish_run();
  end
endmodule